// File: doc/BRIEF.md
# Manchester II Frame Decoder

This block turns a stream of Manchester II half-bit samples into framed words. A clock-recovery front end, which is not part of this block, delivers one sample of the line level per half-bit period. It marks each sample with a one-cycle strobe in the system clock domain. The decoder hunts for a sync character, which deliberately breaks Manchester rules. From the sync it tells a command word from a data word. It then pairs the following half-bit samples into bits and checks each pair for a mid-bit transition.

Output begins only after the sync and the first two data bits have decoded cleanly. From then on the word leaves as NRZ serial data, one bit per bit period, with a bit strobe. A take-data window and one of two sync-type flags frame the K data bits. The data bit count K is programmed through a five-bit length input, and the same value serves the encoder side of a link. When the window closes, a one-cycle valid-word pulse reports that the word had correct parity and no Manchester errors. The parity sense is selectable. A synchronous decoder reset abandons any word in progress and returns the block to hunting.

Top module: `mdec_decoder`

## Requirements
- R1: A sync is six consecutive half-bit samples of three high followed by three low (command) or three low followed by three high (data). It is recognised only while hunting. During the output window of a command word cmdSync is high and dataSync is low, and the reverse for a data word. The two are never high together.
- R2: If either of the first two bit pairs after a sync lacks a transition, the word is abandoned. takeData, the sync flags and validWord then stay low and hunting resumes.
- R3: takeData rises on the clock edge that samples the fourth half-bit after the sync, which completes the second data bit. It stays high for exactly 2K half-bit strobes.
- R4: A bit is a high-then-low pair for logic 1 and a low-then-high pair for logic 0. serialData presents the K data bits first-received first, each one changing on the edge that completes the following bit pair. bitStb is high for the one clock cycle after each new bit is presented, and only inside the window.
- R5: validWord is high for the single clock cycle after takeData falls. It is high only if every data and parity pair of the word had a transition and parity matched. A word with a bad pair after its first two bits is still output in full.
- R6: Parity covers the K data bits plus the parity bit that follows them. With parityEven = 1 the total count of ones must be even, and with parityEven = 0 it must be odd.
- R7: K equals wordLen, limited to the range 2 to 28. Values below 2 act as 2 and values above 28 act as 28.
- R8: A high decReset at a clock edge abandons the current word. takeData, the sync flags and serialData are low from the next cycle, no validWord follows, and the next sync is decoded normally.
- R9: Sync-like patterns inside a word are ignored and do not restart decoding. Frames sent back to back with no idle gap are each decoded.
- R10: After rstN is asserted all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfStb | input | 1 | One-cycle strobe per recovered half-bit period |
| halfLevel | input | 1 | Line level sampled for the strobed half-bit |
| decReset | input | 1 | Synchronous decoder reset, re-arms word framing |
| parityEven | input | 1 | 1 selects even parity check, 0 selects odd |
| wordLen | input | 5 | Programmed data bit count K |
| serialData | output | 1 | Decoded NRZ data |
| cmdSync | output | 1 | Command-sync word being output |
| dataSync | output | 1 | Data-sync word being output |
| takeData | output | 1 | Output window of the current word |
| bitStb | output | 1 | One-cycle pulse per new serial bit |
| validWord | output | 1 | One-cycle pulse for a clean, parity-correct word |

## Verification
The bench goes after errored pairs at the first two bits and later in the word. A design that did not abort early would raise takeData for garbage. One that aborted late would drop words that should be delivered and flagged invalid. Both parity senses are checked against flipped parity bits, and a swapped sense would invert validWord. The length limits are checked at wordLen 0 and 31, where an unclamped counter ends the window too early or never. Further cases are a sync-shaped run of halves inside a word, back-to-back frames and a mid-word decoder reset. Each of these exposes a decoder that re-arms or hunts at the wrong time, because the window then restarts, swallows the next sync or leaks a stale valid pulse.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Strobes issued by the control FSM to the datapath, all qualified per cycle
  typedef struct packed {
    logic loadSync;   // sync accepted: latch type, clear word accumulators
    logic holdHalf;   // first half of a bit pair sampled
    logic takeBit;    // second half sampled: bit complete and kept
    logic present;    // put previous bit on the serial output
    logic endWord;    // close the output window, judge the word
    logic clearAll;   // abandon word, drop outputs
  } mdecStrobes_t;

endpackage

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
  import mdec_pkg::*;
#(
  parameter int LEN_W    = 5,
  parameter int WORD_MIN = 2,
  parameter int WORD_MAX = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfStb,
  input  logic             decReset,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             syncHit,
  input  logic             bitOk,
  output mdecStrobes_t     strobes
);

  localparam int CNT_W = $clog2(WORD_MAX + 2);
  localparam int LEAD_BITS = 2;  // clean bits needed before output starts

  typedef enum logic [1:0] {HUNT, RECV, TAIL} ctrlState_t;

  ctrlState_t       state, stateNext;
  logic             phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic [CNT_W-1:0] kEff;

  // Effective word length, limited to the supported range
  always_comb begin
    if (wordLen < LEN_W'(WORD_MIN))      kEff = CNT_W'(WORD_MIN);
    else if (wordLen > LEN_W'(WORD_MAX)) kEff = CNT_W'(WORD_MAX);
    else                                 kEff = CNT_W'(wordLen);
  end

  always_comb begin
    strobes    = '0;
    stateNext  = state;
    phaseNext  = phase;
    bitCntNext = bitCnt;
    if (decReset) begin
      strobes.clearAll = 1'b1;
      stateNext        = HUNT;
      phaseNext        = 1'b0;
      bitCntNext       = '0;
    end else if (halfStb) begin
      unique case (state)
        HUNT: begin
          if (syncHit) begin
            strobes.loadSync = 1'b1;
            stateNext        = RECV;
            phaseNext        = 1'b0;
            bitCntNext       = '0;
          end
        end
        RECV: begin
          if (!phase) begin
            strobes.holdHalf = 1'b1;
            phaseNext        = 1'b1;
          end else begin
            phaseNext = 1'b0;
            if (!bitOk && (bitCnt < CNT_W'(LEAD_BITS))) begin
              strobes.clearAll = 1'b1;
              stateNext        = HUNT;
            end else begin
              strobes.takeBit = 1'b1;
              strobes.present = (bitCnt != '0);
              bitCntNext      = bitCnt + CNT_W'(1);
              if (bitCnt == kEff) stateNext = TAIL;
            end
          end
        end
        TAIL: begin
          if (!phase) begin
            phaseNext = 1'b1;
          end else begin
            phaseNext       = 1'b0;
            strobes.endWord = 1'b1;
            stateNext       = HUNT;
          end
        end
        default: stateNext = HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HUNT;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      bitCnt <= bitCntNext;
    end
  end

endmodule

// File: rtl/mdec_datapath.sv
module mdec_datapath
  import mdec_pkg::*;
#(
  parameter int SYNC_RUN = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         halfStb,
  input  logic         halfLevel,
  input  logic         parityEven,
  input  mdecStrobes_t strobes,
  output logic         syncHit,
  output logic         bitOk,
  output logic         serialData,
  output logic         cmdSync,
  output logic         dataSync,
  output logic         takeData,
  output logic         bitStb,
  output logic         validWord
);

  localparam int HIST_W = 2 * SYNC_RUN;
  localparam int FILL_W = $clog2(HIST_W);
  localparam logic [HIST_W-1:0] CMD_PAT  = {{SYNC_RUN{1'b1}}, {SYNC_RUN{1'b0}}};
  localparam logic [HIST_W-1:0] DATA_PAT = ~CMD_PAT;

  logic [HIST_W-2:0] hist;
  logic [FILL_W-1:0] fill;
  logic [HIST_W-1:0] window;
  logic              fillOk, isCmdHit, isDataHit;
  logic              firstHalf, heldBit, isCmd, parAcc, errSeen;
  logic              parityGood;

  // Sliding window of the last HIST_W half-bit samples, newest in bit 0
  assign window    = {hist, halfLevel};
  assign fillOk    = (fill == FILL_W'(HIST_W - 1));
  assign isCmdHit  = (window == CMD_PAT);
  assign isDataHit = (window == DATA_PAT);
  assign syncHit   = fillOk && (isCmdHit || isDataHit);

  // A bit pair is legal only with a mid-bit transition
  assign bitOk = (firstHalf != halfLevel);

  assign parityGood = parityEven ? !parAcc : parAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
      fill <= '0;
    end else if (halfStb) begin
      hist <= window[HIST_W-2:0];
      if (!fillOk) fill <= fill + FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstHalf <= 1'b0;
      heldBit   <= 1'b0;
      isCmd     <= 1'b0;
      parAcc    <= 1'b0;
      errSeen   <= 1'b0;
    end else begin
      if (strobes.loadSync) begin
        isCmd   <= isCmdHit;
        parAcc  <= 1'b0;
        errSeen <= 1'b0;
      end
      if (strobes.holdHalf) firstHalf <= halfLevel;
      if (strobes.takeBit) begin
        heldBit <= firstHalf;
        parAcc  <= parAcc ^ firstHalf;
        if (!bitOk) errSeen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialData <= 1'b0;
      cmdSync    <= 1'b0;
      dataSync   <= 1'b0;
      takeData   <= 1'b0;
      bitStb     <= 1'b0;
      validWord  <= 1'b0;
    end else begin
      bitStb    <= strobes.present;
      validWord <= strobes.endWord && parityGood && !errSeen;
      if (strobes.clearAll || strobes.endWord) begin
        serialData <= 1'b0;
        cmdSync    <= 1'b0;
        dataSync   <= 1'b0;
        takeData   <= 1'b0;
      end else if (strobes.present) begin
        serialData <= heldBit;
        cmdSync    <= isCmd;
        dataSync   <= !isCmd;
        takeData   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdec_decoder.sv
module mdec_decoder
  import mdec_pkg::*;
#(
  parameter int LEN_W    = 5,
  parameter int WORD_MIN = 2,
  parameter int WORD_MAX = 28,
  parameter int SYNC_RUN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfStb,
  input  logic             halfLevel,
  input  logic             decReset,
  input  logic             parityEven,
  input  logic [LEN_W-1:0] wordLen,
  output logic             serialData,
  output logic             cmdSync,
  output logic             dataSync,
  output logic             takeData,
  output logic             bitStb,
  output logic             validWord
);

  mdecStrobes_t strobes;
  logic         syncHit, bitOk;

  mdec_ctrl #(
    .LEN_W(LEN_W), .WORD_MIN(WORD_MIN), .WORD_MAX(WORD_MAX)
  ) ctrl (
    .clk(clk), .rstN(rstN), .halfStb(halfStb), .decReset(decReset),
    .wordLen(wordLen), .syncHit(syncHit), .bitOk(bitOk), .strobes(strobes)
  );

  mdec_datapath #(
    .SYNC_RUN(SYNC_RUN)
  ) dp (
    .clk(clk), .rstN(rstN), .halfStb(halfStb), .halfLevel(halfLevel),
    .parityEven(parityEven), .strobes(strobes), .syncHit(syncHit),
    .bitOk(bitOk), .serialData(serialData), .cmdSync(cmdSync),
    .dataSync(dataSync), .takeData(takeData), .bitStb(bitStb),
    .validWord(validWord)
  );

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker (
  input logic clk,
  input logic rstN,
  input logic halfStb,
  input logic decReset,
  input logic takeData,
  input logic cmdSync,
  input logic dataSync,
  input logic bitStb,
  input logic validWord
);

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdSync && dataSync));

  assert_flag_in_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSync || dataSync) |-> takeData);

  assert_take_starts_on_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(takeData) |-> $past(halfStb));

  assert_bitstb_in_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitStb |-> takeData);

  assert_valid_after_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    validWord |-> (!takeData && $past(takeData)));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    decReset |=> (!takeData && !cmdSync && !dataSync && !validWord));

endmodule

bind mdec_decoder mdec_checker chk (
  .clk(clk), .rstN(rstN), .halfStb(halfStb), .decReset(decReset),
  .takeData(takeData), .cmdSync(cmdSync), .dataSync(dataSync),
  .bitStb(bitStb), .validWord(validWord)
);

// File: tb/mdec_decoder_test.sv
module mdec_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfStb = 1'b0;
  logic       halfLevel = 1'b0;
  logic       decReset = 1'b0;
  logic       parityEven = 1'b1;
  logic [4:0] wordLen = 5'd8;
  logic       serialData, cmdSync, dataSync, takeData, bitStb, validWord;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit finished = 0;

  mdec_decoder uut (
    .clk(clk), .rstN(rstN), .halfStb(halfStb), .halfLevel(halfLevel),
    .decReset(decReset), .parityEven(parityEven), .wordLen(wordLen),
    .serialData(serialData), .cmdSync(cmdSync), .dataSync(dataSync),
    .takeData(takeData), .bitStb(bitStb), .validWord(validWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int kOf(int w);
    if (w < 2) return 2;
    if (w > 28) return 28;
    return w;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit histQ[$];
  bit bitsQ[$];
  int mode = 0;          // 0 hunting, 1 receiving, 2 trailing
  int halfCount, tailCount;
  bit firstH, wordErr, wordIsCmd;
  bit expSer, expCmd, expDat, expTake, expStb, expValid;

  always @(posedge clk) begin
    expStb   = 0;
    expValid = 0;
    if (!rstN) begin
      mode = 0; histQ.delete(); bitsQ.delete();
      expSer = 0; expCmd = 0; expDat = 0; expTake = 0;
    end else begin
      if (decReset) begin
        mode = 0;
        expSer = 0; expCmd = 0; expDat = 0; expTake = 0;
      end else if (halfStb) begin
        if (mode == 0) begin
          if (histQ.size() == 5) begin
            bit seeCmd, seeDat;
            seeCmd = histQ[0] && histQ[1] && histQ[2] && !histQ[3] && !histQ[4] && !halfLevel;
            seeDat = !histQ[0] && !histQ[1] && !histQ[2] && histQ[3] && histQ[4] && halfLevel;
            if (seeCmd || seeDat) begin
              mode = 1; halfCount = 0; bitsQ.delete(); wordErr = 0; wordIsCmd = seeCmd;
            end
          end
        end else if (mode == 1) begin
          halfCount++;
          if (halfCount % 2 == 1) firstH = halfLevel;
          else begin
            bit good;
            good = (firstH != halfLevel);
            if (!good && bitsQ.size() < 2) mode = 0;
            else begin
              int n;
              bitsQ.push_back(firstH);
              if (!good) wordErr = 1;
              n = bitsQ.size();
              if (n >= 2) begin
                expSer = bitsQ[n-2]; expTake = 1; expStb = 1;
                expCmd = wordIsCmd; expDat = !wordIsCmd;
              end
              if (n == kOf(int'(wordLen)) + 1) begin mode = 2; tailCount = 0; end
            end
          end
        end else begin
          tailCount++;
          if (tailCount == 2) begin
            int ones;
            ones = 0;
            foreach (bitsQ[i]) ones += int'(bitsQ[i]);
            expValid = !wordErr && (parityEven ? (ones % 2 == 0) : (ones % 2 == 1));
            expSer = 0; expCmd = 0; expDat = 0; expTake = 0;
            mode = 0;
          end
        end
      end
      if (halfStb) begin
        histQ.push_back(halfLevel);
        if (histQ.size() > 5) void'(histQ.pop_front());
      end
    end
  end

  // ---------------- checking ----------------
  task automatic cmpBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpInt(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int  nValid, nTakeRise, nCmdRise, nDatRise, nTakeCycles, obsN;
  logic [31:0] obsWord;
  logic prevTake = 0, prevCmd = 0, prevDat = 0;

  always @(negedge clk) begin
    if (running) begin
      cmpBit("R3 takeData", takeData, expTake);
      cmpBit("R1 cmdSync", cmdSync, expCmd);
      cmpBit("R1 dataSync", dataSync, expDat);
      cmpBit("R4 serialData", serialData, expSer);
      cmpBit("R4 bitStb", bitStb, expStb);
      cmpBit("R5 validWord", validWord, expValid);
      if (validWord) nValid++;
      if (takeData && !prevTake) nTakeRise++;
      if (cmdSync && !prevCmd) nCmdRise++;
      if (dataSync && !prevDat) nDatRise++;
      if (takeData) nTakeCycles++;
      if (bitStb) begin obsWord = {obsWord[30:0], serialData}; obsN++; end
      prevTake = takeData; prevCmd = cmdSync; prevDat = dataSync;
    end
  end

  task automatic clearCounts();
    nValid = 0; nTakeRise = 0; nCmdRise = 0; nDatRise = 0;
    nTakeCycles = 0; obsN = 0; obsWord = '0;
  endtask

  // ---------------- stimulus ----------------
  task automatic sendHalf(bit lv);
    @(negedge clk); halfLevel = lv; halfStb = 1'b1;
    @(negedge clk); halfStb = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendSync(bit cmd);
    for (int i = 0; i < 6; i++) sendHalf((i < 3) ? cmd : !cmd);
  endtask

  // logic 1 = high then low; a flagged error sends both halves at the bit level
  task automatic sendBit(bit b, bit bad);
    sendHalf(b);
    sendHalf(bad ? b : !b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) sendHalf(1'b0);
  endtask

  function automatic bit parFor(logic [27:0] d, int k, bit even, bit good);
    int ones;
    ones = 0;
    for (int i = 0; i < k; i++) ones += int'(d[i]);
    return ((even ? (ones % 2 == 1) : (ones % 2 == 0)) ^ !good);
  endfunction

  // errMask bit i marks the i-th bit sent (0 = first data bit, K = parity)
  task automatic sendFrame(bit cmd, logic [27:0] d, bit parGood, logic [28:0] errMask);
    int k;
    k = kOf(int'(wordLen));
    sendSync(cmd);
    for (int i = 0; i < k; i++) sendBit(d[k-1-i], errMask[i]);
    sendBit(parFor(d, k, parityEven, parGood), errMask[k]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    cmpBit("R10 takeData reset", takeData, 1'b0);
    cmpBit("R10 cmdSync reset", cmdSync, 1'b0);
    cmpBit("R10 dataSync reset", dataSync, 1'b0);
    cmpBit("R10 serialData reset", serialData, 1'b0);
    cmpBit("R10 bitStb reset", bitStb, 1'b0);
    cmpBit("R10 validWord reset", validWord, 1'b0);
    rstN = 1'b1;
    running = 1;
    idle(8);

    // R1 R3 R4 R5: clean command word
    clearCounts();
    sendFrame(1'b1, 28'hA5, 1'b1, '0); idle(4);
    cmpInt("R1 command flag rises", nCmdRise, 1);
    cmpInt("R1 data flag stays low", nDatRise, 0);
    cmpInt("R3 take window cycles", nTakeCycles, 48);
    cmpInt("R4 bit count", obsN, 8);
    cmpInt("R4 serial word", int'(obsWord[7:0]), 'hA5);
    cmpInt("R5 valid command word", nValid, 1);

    // R1: clean data word
    clearCounts();
    sendFrame(1'b0, 28'h3C, 1'b1, '0); idle(4);
    cmpInt("R1 data flag rises", nDatRise, 1);
    cmpInt("R1 command flag stays low", nCmdRise, 0);
    cmpInt("R5 valid data word", nValid, 1);

    // R6: parity sense
    clearCounts();
    sendFrame(1'b1, 28'h71, 1'b0, '0); idle(4);
    cmpInt("R6 even parity mismatch", nValid, 0);
    parityEven = 1'b0;
    clearCounts();
    sendFrame(1'b0, 28'h71, 1'b1, '0); idle(4);
    cmpInt("R6 odd parity match", nValid, 1);
    clearCounts();
    sendFrame(1'b0, 28'h71, 1'b0, '0); idle(4);
    cmpInt("R6 odd parity mismatch", nValid, 0);
    parityEven = 1'b1;

    // R5: late Manchester error still outputs the word
    clearCounts();
    sendFrame(1'b1, 28'hC3, 1'b1, 29'h20); idle(4);
    cmpInt("R5 late error take rises", nTakeRise, 1);
    cmpInt("R5 late error no valid", nValid, 0);

    // R2: error in second bit abandons the word
    clearCounts();
    sendFrame(1'b1, 28'h5A, 1'b1, 29'h2); idle(4);
    cmpInt("R2 no take after early error", nTakeRise, 0);
    cmpInt("R2 no valid after early error", nValid, 0);

    // R7: length limits
    wordLen = 5'd0;
    clearCounts();
    sendFrame(1'b1, 28'h2, 1'b1, '0); idle(4);
    cmpInt("R7 short length bits", obsN, 2);
    cmpInt("R7 short length valid", nValid, 1);
    wordLen = 5'd31;
    clearCounts();
    sendFrame(1'b0, 28'hABCDE12, 1'b1, '0); idle(4);
    cmpInt("R7 long length bits", obsN, 28);
    cmpInt("R7 long length word", int'(obsWord[27:0]), 'hABCDE12);
    cmpInt("R7 long length valid", nValid, 1);
    wordLen = 5'd8;

    // R8: decoder reset mid-word
    clearCounts();
    sendSync(1'b1);
    sendBit(1'b1, 1'b0); sendBit(1'b0, 1'b0); sendBit(1'b1, 1'b0);
    @(negedge clk); decReset = 1'b1;
    @(negedge clk); decReset = 1'b0;
    cmpBit("R8 take cleared", takeData, 1'b0);
    cmpBit("R8 flag cleared", cmdSync, 1'b0);
    idle(6);
    cmpInt("R8 no valid after reset", nValid, 0);
    clearCounts();
    sendFrame(1'b0, 28'h96, 1'b1, '0); idle(4);
    cmpInt("R8 next word decoded", nValid, 1);

    // R9: sync-shaped halves inside a word, then back-to-back frames
    clearCounts();
    sendFrame(1'b1, 28'h30, 1'b1, 29'h14); idle(4);
    cmpInt("R9 in-word sync ignored take", nTakeRise, 1);
    cmpInt("R9 in-word sync bits", obsN, 8);
    cmpInt("R9 in-word sync no valid", nValid, 0);
    clearCounts();
    sendFrame(1'b1, 28'hE1, 1'b1, '0);
    sendFrame(1'b0, 28'h4B, 1'b1, '0);
    sendFrame(1'b1, 28'h0F, 1'b1, '0);
    idle(4);
    cmpInt("R9 back-to-back valid", nValid, 3);
    cmpInt("R9 back-to-back windows", nTakeRise, 3);

    running = 0;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule